// File: doc/BRIEF.md
# Six-Channel DMA Request Arbiter

This block chooses which of six DMA channels may start the next transfer. Each channel raises its bit of a request vector. When the arbiter is free, it takes a snapshot of the requests and picks one winner. In the following cycle it drives a one-hot grant together with a one-cycle valid strobe. Three ranking schemes are available:

- a straight numeric order;
- a fixed order that moves channel 1 below channels 2 and 3;
- a rotating scheme in which the channel just served drops to last place.

A 16-bit control word holds two 2-bit fields: the ranking scheme and a grant-spacing setting. Every other bit of the word reads back as zero.

The spacing setting is for systems whose channels all run in cycle-steal bus mode. In that case it can limit the arbiter to one grant per 16 or per 64 external bus clocks. The external bus clock arrives as a one-cycle enable strobe. If any channel is not in cycle-steal mode, the spacing setting has no effect.

The control is a three-state machine:

- READY: samples the requests. On any request it goes to ISSUE.
- ISSUE: drives the grant for one cycle. It then goes to WAIT when spacing is active, and back to READY when it is not.
- WAIT: counts bus strobes. It returns to READY when the count completes. It also returns to READY at once when spacing is switched off, when any channel leaves cycle-steal mode, or when the spacing length changes.

Top module: `dma_req_arbiter`

## Requirements
- R1: `gnt` is one-hot while `gnt_valid` is 1 and all-zero otherwise. `gnt_valid` is never high in two consecutive cycles.
- R2: A grant goes only to a channel whose request was high at the clock edge that started the grant. With no request pending, no grant is issued.
- R3: `cfg_wdata` is stored on a clock edge with `cfg_we` high. The spacing field sits in bits 13:12 and the ranking field in bits 9:8. Every other bit of `cfg_rdata` reads 0 whatever was written. After reset the whole word is 0.
- R4: Ranking code 00 serves the lowest-numbered requesting channel: 0 before 1, 1 before 2, and so on up to 5.
- R5: Ranking code 01 serves in the order 0, 2, 3, 1, 4, 5, earliest first.
- R6: Ranking code 11 rotates. A rotation pointer names the highest-ranked channel, and the search goes upward from it, wrapping from 5 to 0. Every grant, in any mode, moves the pointer to the channel after the one just granted. Reset sets the pointer to channel 0.
- R7: Ranking code 10 behaves exactly like code 00.
- R8: Spacing code 10 requires 16 `bus_tick` strobes, counted in WAIT, before the next grant. Spacing code 11 requires 64. The grant follows the final strobe by two clock edges.
- R9: Spacing codes 00 and 01 never delay a grant. Codes 10 and 11 also do not delay a grant unless every bit of `steal_mode` is 1.
- R10: The first grant after reset is never delayed by spacing. The same holds for the first grant after the spacing length changes while in WAIT.
- R11: A request present at a clock edge in READY shows as `gnt`/`gnt_valid` in the next cycle. A request held steadily without spacing is granted every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 6 | One request bit per channel |
| steal_mode | input | 6 | One bit per channel, 1 means the channel is in cycle-steal bus mode |
| bus_tick | input | 1 | One-cycle strobe per external bus clock |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data, reserved bits zero |
| gnt | output | 6 | One-hot grant |
| gnt_valid | output | 1 | One-cycle grant strobe |

## Verification
Most internal faults in this block reach the ports within one grant.

- A wrong rotation pointer puts the wrong bit in `gnt` on the next grant in rotating mode. That grant appears one cycle after the requests are sampled.
- A winner register that is stale or mis-encoded shows up in the same cycle as the grant.
- A spacing counter that is off by one, or compares against the wrong limit, moves the first grant after the final strobe. That grant then comes one strobe early or late, or appears while strobes are still outstanding.
- A WAIT state that does not notice a mode change withholds the grant that should follow at once.
- Pulse width and one-hot shape are checked on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NCH = 6;
    localparam int CHW = $clog2(NCH);

    typedef logic [CHW-1:0] chan_t;

    typedef enum logic [1:0] {
        PM_LINEAR = 2'b00,
        PM_SPLIT  = 2'b01,
        PM_UNUSED = 2'b10,
        PM_ROTATE = 2'b11
    } prio_e;

    typedef enum logic [1:0] {
        CS_NORMAL = 2'b00,
        CS_UNUSED = 2'b01,
        CS_GAP_A  = 2'b10,
        CS_GAP_B  = 2'b11
    } steal_e;

    typedef enum logic [1:0] {
        ST_READY = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10
    } state_e;

    // Channel ranked at position pos under the split fixed order
    function automatic chan_t split_rank(input int pos);
        chan_t c;
        case (pos)
            0:       c = chan_t'(0);
            1:       c = chan_t'(2);
            2:       c = chan_t'(3);
            3:       c = chan_t'(1);
            4:       c = chan_t'(4);
            default: c = chan_t'(5);
        endcase
        return c;
    endfunction

    // Channel number step places after base, modulo NCH
    function automatic chan_t wrap_add(input chan_t base, input int step);
        int s;
        s = int'(base) + step;
        if (s >= NCH) s = s - NCH;
        return chan_t'(s);
    endfunction

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
    import arb_pkg::*;
#(
    parameter int W      = 16,
    parameter int CS_LSB = 12,
    parameter int PM_LSB = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output steal_e       cs,
    output prio_e        pm
);

    localparam logic [W-1:0] FIELD_MASK = (W'(3) << CS_LSB) | (W'(3) << PM_LSB);

    logic [W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we) begin
            word_q <= wdata & FIELD_MASK;
        end
    end

    always_comb begin
        rdata = word_q;
        cs    = steal_e'(word_q[CS_LSB +: 2]);
        pm    = prio_e'(word_q[PM_LSB +: 2]);
    end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
(
    input  logic [NCH-1:0] req,
    input  prio_e          pm,
    input  chan_t          ptr,
    output logic           any,
    output chan_t          win
);

    prio_e                     mode;
    logic [NCH-1:0]            hit;
    logic [NCH-1:0][CHW-1:0]   cand;

    // The unused code falls back to the linear order
    always_comb begin
        mode = (pm == PM_UNUSED) ? PM_LINEAR : pm;
    end

    // One candidate channel per rank position
    for (genvar p = 0; p < NCH; p++) begin : g_pos
        chan_t          c;
        logic [NCH-1:0] onehot;
        always_comb begin
            unique case (mode)
                PM_SPLIT:  c = split_rank(p);
                PM_ROTATE: c = wrap_add(ptr, p);
                default:   c = chan_t'(p);
            endcase
            onehot = NCH'(1) << c;
        end
        assign hit[p]  = |(req & onehot);
        assign cand[p] = c;
    end

    // Lowest rank position that holds a request wins
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int p = NCH - 1; p >= 0; p--) begin
            if (hit[p]) begin
                any = 1'b1;
                win = cand[p];
            end
        end
    end

endmodule

// File: rtl/arb_throttle.sv
module arb_throttle #(
    parameter int GAP_A = 16,
    parameter int GAP_B = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    input  logic long_gap,
    output logic expired
);

    localparam int GAP_MAX = (GAP_A > GAP_B) ? GAP_A : GAP_B;
    localparam int CW      = $clog2(GAP_MAX + 1);
    localparam logic [CW-1:0] LAST_A = CW'(GAP_A - 1);
    localparam logic [CW-1:0] LAST_B = CW'(GAP_B - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        last    = long_gap ? LAST_B : LAST_A;
        expired = run && tick && (cnt_q == last);
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import arb_pkg::*;
#(
    parameter int GAP_A  = 16,
    parameter int GAP_B  = 64,
    parameter int CFG_W  = 16,
    parameter int CS_LSB = 12,
    parameter int PM_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   steal_mode,
    input  logic             bus_tick,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [NCH-1:0]   gnt,
    output logic             gnt_valid
);

    state_e state_q, state_d;
    steal_e cs;
    prio_e  pm;
    chan_t  ptr_q;
    chan_t  win_q;
    chan_t  pick_win;
    logic   pick_any;
    logic   spacing_on;
    logic   long_now;
    logic   long_q;
    logic   gap_done;

    arb_cfg_reg #(
        .W      (CFG_W),
        .CS_LSB (CS_LSB),
        .PM_LSB (PM_LSB)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cs    (cs),
        .pm    (pm)
    );

    arb_pick u_pick (
        .req (req),
        .pm  (pm),
        .ptr (ptr_q),
        .any (pick_any),
        .win (pick_win)
    );

    arb_throttle #(
        .GAP_A (GAP_A),
        .GAP_B (GAP_B)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_ISSUE),
        .run      (state_q == ST_WAIT),
        .tick     (bus_tick),
        .long_gap (long_q),
        .expired  (gap_done)
    );

    // Spacing applies only with a spacing code and every channel stealing cycles
    always_comb begin
        spacing_on = (&steal_mode) && ((cs == CS_GAP_A) || (cs == CS_GAP_B));
        long_now   = (cs == CS_GAP_B);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (pick_any) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                state_d = spacing_on ? ST_WAIT : ST_READY;
            end
            ST_WAIT: begin
                if (!spacing_on || (long_now != long_q) || gap_done) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            win_q   <= '0;
            ptr_q   <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_READY && pick_any) begin
                win_q <= pick_win;
            end
            if (state_q == ST_ISSUE) begin
                ptr_q  <= wrap_add(win_q, 1);
                long_q <= long_now;
            end
        end
    end

    // Outputs
    always_comb begin
        gnt       = '0;
        gnt_valid = 1'b0;
        if (state_q == ST_ISSUE) begin
            gnt[win_q] = 1'b1;
            gnt_valid  = 1'b1;
        end
    end

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NC     = 6,
    parameter int CFG_W  = 16,
    parameter int CS_LSB = 12,
    parameter int PM_LSB = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NC-1:0]    req,
    input logic [NC-1:0]    gnt,
    input logic             gnt_valid,
    input logic [CFG_W-1:0] cfg_rdata
);

    localparam logic [CFG_W-1:0] RSVD = ~((CFG_W'(3) << CS_LSB) | (CFG_W'(3) << PM_LSB));

    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_VALID_HAS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ($countones(gnt) == 1)); // R1

    AST_NO_GNT_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_valid |-> (gnt == '0)); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !gnt_valid); // R1

    AST_GNT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> ((gnt & $past(req)) != '0)); // R2

    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !gnt_valid); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & RSVD) == '0); // R3

endmodule

bind dma_req_arbiter arb_checker #(
    .NC     (arb_pkg::NCH),
    .CFG_W  (CFG_W),
    .CS_LSB (CS_LSB),
    .PM_LSB (PM_LSB)
) u_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .gnt       (gnt),
    .gnt_valid (gnt_valid),
    .cfg_rdata (cfg_rdata)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  req;
    logic [5:0]  steal_mode;
    logic        bus_tick;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic [5:0]  gnt;
    logic        gnt_valid;

    int errs      = 0;
    int checks    = 0;
    int pulse_cnt = 0;
    int ptr_m     = 0;
    logic [1:0] pm_m = 2'b00;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    dma_req_arbiter i_dma_req_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .steal_mode (steal_mode),
        .bus_tick   (bus_tick),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .gnt        (gnt),
        .gnt_valid  (gnt_valid)
    );

    always @(negedge clk) begin
        if (rst_n === 1'b1 && gnt_valid === 1'b1) pulse_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // Expected winner from the ranking rules, -1 when nothing requests
    function automatic int pick(input logic [5:0] r, input logic [1:0] pm, input int ptr);
        int ch;
        for (int p = 0; p < 6; p++) begin
            if (pm == 2'b01) begin
                case (p)
                    0: ch = 0;
                    1: ch = 2;
                    2: ch = 3;
                    3: ch = 1;
                    4: ch = 4;
                    default: ch = 5;
                endcase
            end else if (pm == 2'b11) begin
                ch = (ptr + p) % 6;
            end else begin
                ch = p;
            end
            if (r[ch]) return ch;
        end
        return -1;
    endfunction

    // Starts and ends at a falling edge
    task automatic write_cfg(input logic [1:0] cs, input logic [1:0] pm);
        logic [15:0] w;
        w = 16'($urandom);
        w[13:12] = cs;
        w[9:8]   = pm;
        cfg_wdata = w;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pm_m = pm;
        check(cfg_rdata === {2'b00, cs, 2'b00, pm, 8'h00}, "R3 readback",
              int'(cfg_rdata), int'({2'b00, cs, 2'b00, pm, 8'h00}));
    endtask

    task automatic grant_once(input logic [5:0] r, input string tag);
        int e;
        req = r;
        @(negedge clk);
        e = pick(r, pm_m, ptr_m);
        if (e < 0) begin
            check(gnt_valid === 1'b0 && gnt === 6'h00, tag, int'({gnt_valid, gnt}), 0);
        end else begin
            check(gnt_valid === 1'b1 && gnt === 6'(1 << e), tag,
                  int'({gnt_valid, gnt}), 64 | (1 << e));
            ptr_m = (e + 1) % 6;
        end
        req = '0;
        @(negedge clk);
    endtask

    // Called in WAIT: n-1 strobes must not release a grant, the n-th must
    task automatic spacing_run(input int n, input logic [5:0] r, input string tag);
        int base;
        int e;
        req  = r;
        base = pulse_cnt;
        for (int i = 0; i < n - 1; i++) begin
            bus_tick = 1'b1;
            @(negedge clk);
            bus_tick = 1'b0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(pulse_cnt == base && gnt_valid === 1'b0, {tag, " early"}, pulse_cnt - base, 0);
        bus_tick = 1'b1;
        @(negedge clk);
        bus_tick = 1'b0;
        check(gnt_valid === 1'b0, {tag, " one edge after last strobe"}, int'(gnt_valid), 0);
        @(negedge clk);
        e = pick(r, pm_m, ptr_m);
        check(gnt_valid === 1'b1 && gnt === 6'(1 << e), {tag, " release"},
              int'({gnt_valid, gnt}), 64 | (1 << e));
        ptr_m = (e + 1) % 6;
        req = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WATCHDOG", 0, 1);
        finish_run();
    end

    initial begin
        logic [5:0] r;
        void'($urandom(32'd7741));
        rst_n      = 1'b0;
        req        = '0;
        steal_mode = '0;
        bus_tick   = 1'b0;
        cfg_we     = 1'b0;
        cfg_wdata  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(cfg_rdata === 16'h0000, "R3 reset value", int'(cfg_rdata), 0);
        check(gnt === 6'h00 && gnt_valid === 1'b0, "R1 reset outputs", int'({gnt_valid, gnt}), 0);

        // R2: nothing requested, nothing granted
        grant_once(6'b000000, "R2 idle");

        // R4 linear order
        write_cfg(2'b00, 2'b00);
        grant_once(6'b111111, "R4 all");
        grant_once(6'b111110, "R4 no ch0");
        grant_once(6'b101010, "R4 odd");
        grant_once(6'b110000, "R4 high pair");
        grant_once(6'b100000, "R4 ch5 only");

        // R5 split order
        write_cfg(2'b00, 2'b01);
        grant_once(6'b001110, "R5 2 over 1");
        grant_once(6'b001010, "R5 3 over 1");
        grant_once(6'b110010, "R5 1 over 4");
        grant_once(6'b110000, "R5 4 over 5");
        grant_once(6'b111111, "R5 0 first");

        // R7 unused code acts as linear
        write_cfg(2'b00, 2'b10);
        grant_once(6'b001110, "R7 1 over 2");
        grant_once(6'b011000, "R7 3 over 4");

        // R6 rotation
        write_cfg(2'b00, 2'b11);
        for (int k = 0; k < 7; k++) grant_once(6'b111111, "R6 rotate all");
        grant_once(6'b100001, "R6 wrap pair");
        grant_once(6'b100001, "R6 wrap pair again");

        // R11 back-to-back under a held request
        write_cfg(2'b00, 2'b00);
        req = 6'b000110;
        @(negedge clk);
        check(gnt_valid === 1'b1 && gnt === 6'b000010, "R11 first", int'({gnt_valid, gnt}), 'h42);
        @(negedge clk);
        check(gnt_valid === 1'b0, "R11 gap cycle", int'(gnt_valid), 0);
        @(negedge clk);
        check(gnt_valid === 1'b1 && gnt === 6'b000010, "R11 second", int'({gnt_valid, gnt}), 'h42);
        ptr_m = 2;
        req = '0;
        @(negedge clk);

        // Random mix of orders and request patterns
        for (int it = 0; it < 300; it++) begin
            if ($urandom % 8 == 0) write_cfg(2'b00, 2'($urandom));
            r = 6'($urandom);
            if ($urandom % 5 == 0) r = '0;
            case (pm_m)
                2'b00:   grant_once(r, "R4 random");
                2'b01:   grant_once(r, "R5 random");
                2'b10:   grant_once(r, "R7 random");
                default: grant_once(r, "R6 random");
            endcase
        end

        // R9: spacing ignored unless every channel steals cycles
        steal_mode = 6'b011111;
        write_cfg(2'b10, 2'b00);
        grant_once(6'b000001, "R9 partial steal first");
        grant_once(6'b000001, "R9 partial steal no delay");
        steal_mode = 6'b111111;
        write_cfg(2'b01, 2'b00);
        grant_once(6'b000100, "R9 unused spacing code first");
        grant_once(6'b000100, "R9 unused spacing code no delay");
        write_cfg(2'b00, 2'b00);
        grant_once(6'b001000, "R9 normal no delay");

        // R8 / R10: 16-strobe spacing
        write_cfg(2'b10, 2'b00);
        grant_once(6'b000010, "R10 first grant not delayed");
        spacing_run(16, 6'b000010, "R8 gap 16");

        // R10: length change in WAIT releases at once; then 64-strobe spacing
        write_cfg(2'b11, 2'b00);
        grant_once(6'b010000, "R10 grant after length change");
        spacing_run(64, 6'b010000, "R8 gap 64");

        // R9: a channel leaving cycle-steal mode in WAIT frees the arbiter
        steal_mode = 6'b111011;
        @(negedge clk);
        grant_once(6'b100000, "R9 steal dropped in wait");

        finish_run();
    end

endmodule